// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block sits on a processor's auxiliary register bus and carries out maintenance commands on a data-cache tag and state array that it holds itself. Software uses a control register to disable the cache, to pick how an invalidate treats dirty lines, and to poll a busy flag. Commands act either on the whole cache or on one line. A whole-cache command walks every set and way in ascending order. A single-line command takes its set index from a virtual address written to the command register. It takes the tag to match from a separate physical-tag register.

Dirty lines are handed one at a time to a write-back stub port through a valid/ready handshake. While any write-back or whole-cache walk is in progress the busy flag reads as 1. Further register writes are held off with a low ready, while reads stay available so that the busy flag can be polled. The state array can be preloaded through a fill port and inspected through a probe port. The data array and the memory side are not part of this block.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset the control register (0x48) reads 0, the physical-tag register (0x5C) reads 0, dc_disable is 0 and every line is invalid.
- R2: Control bit 0 (disable) and bit 6 (invalidate mode) are read/write, and bit 0 drives dc_disable. Bit 8 is read-only, so writing 1 to it leaves it 0 while idle.
- R3: Control bit 8 reads 1 while a whole-cache walk or a line write-back is in progress and 0 once it finishes. Reads are accepted while busy.
- R4: A register write issued while busy is held with bus_ready low until the operation ends, and then takes effect.
- R5: Writing a value with bit 0 set to 0x47 while invalidate mode is 0 clears valid and dirty on every line and issues no write-back.
- R6: The same command with invalidate mode 1 writes back each dirty line and then clears valid and dirty on every line.
- R7: Writing a value with bit 0 set to 0x4B writes back each dirty line and clears only its dirty bit. Write-backs come in ascending set order and, within a set, ascending way order. Each request holds steady until wb_ready.
- R8: A write to 0x47 or 0x4B with bit 0 clear starts nothing: busy stays 0 and no line changes.
- R9: A write to 0x4A selects set wdata[OFF_W+SET_W-1:OFF_W] and matches the tag held in 0x5C. On a hit it clears valid and dirty. A dirty hit is written back first only when invalidate mode is 1.
- R10: A write to 0x4C uses the same selection. On a dirty hit it writes the line back and clears only the dirty bit. On a clean hit nothing changes.
- R11: A line command whose tag matches no valid way of the selected set changes no line, issues no write-back and leaves busy at 0.
- R12: With wb_ready held high, a whole-cache command keeps busy high for exactly SETS*WAYS cycles plus one cycle for each line written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle (low for writes while busy) |
| bus_rdata | output | 32 | Read data for bus_addr |
| dc_disable | output | 1 | Cache disable, from control bit 0 |
| fill_en | input | 1 | Load one line's state |
| fill_set | input | SET_W | Set to load |
| fill_way | input | WAY_W | Way to load |
| fill_tag | input | TAG_W | Tag to load (line becomes valid) |
| fill_dirty | input | 1 | Dirty bit to load |
| probe_set | input | SET_W | Set to inspect |
| probe_way | input | WAY_W | Way to inspect |
| probe_valid | output | 1 | Valid bit of probed line |
| probe_dirty | output | 1 | Dirty bit of probed line |
| probe_tag | output | TAG_W | Tag of probed line |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_set | output | SET_W | Set of line written back |
| wb_way | output | WAY_W | Way of line written back |
| wb_tag | output | TAG_W | Tag of line written back |

## Verification
The bench builds the block with 4 sets, 2 ways, 8-bit tags and 16-byte lines. A whole-cache walk therefore covers 8 entries, and every line can be preloaded and probed one by one. With that size the exact busy length of a walk with a known number of dirty lines can be checked, and so can the full write-back order under a toggling wb_ready. Every combination of dirty state, invalidate mode, command kind and tag match on a single line is also covered.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam logic [11:0] RA_ALL_INV  = 12'h047;
    localparam logic [11:0] RA_CTRL     = 12'h048;
    localparam logic [11:0] RA_LINE_INV = 12'h04A;
    localparam logic [11:0] RA_ALL_FLS  = 12'h04B;
    localparam logic [11:0] RA_LINE_FLS = 12'h04C;
    localparam logic [11:0] RA_PTAG     = 12'h05C;

    typedef enum logic [1:0] {
        MOP_INV_DROP = 2'd0,
        MOP_INV_WB   = 2'd1,
        MOP_FLUSH    = 2'd2
    } mop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_WB   = 2'd2
    } wst_e;
endpackage

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             upd_clr_valid,
    input  logic             upd_clr_dirty,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic             lk_dirty,
    input  logic [SET_W-1:0] pr_set,
    input  logic [WAY_W-1:0] pr_way,
    output logic             pr_valid,
    output logic             pr_dirty,
    output logic [TAG_W-1:0] pr_tag
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } ent_t;

    ent_t mem_q [ENTRIES];
    ent_t mem_d [ENTRIES];

    function automatic logic [ENT_W-1:0] flat(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w);
        return ENT_W'(s) * ENT_W'(WAYS) + ENT_W'(w);
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (fill_en) begin
            mem_d[flat(fill_set, fill_way)] = '{valid: 1'b1, dirty: fill_dirty, tag: fill_tag};
        end
        if (upd_en) begin
            if (upd_clr_valid) mem_d[flat(upd_set, upd_way)].valid = 1'b0;
            if (upd_clr_dirty) mem_d[flat(upd_set, upd_way)].dirty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_valid = mem_q[flat(rd_set, rd_way)].valid;
        rd_dirty = mem_q[flat(rd_set, rd_way)].dirty;
        rd_tag   = mem_q[flat(rd_set, rd_way)].tag;
        pr_valid = mem_q[flat(pr_set, pr_way)].valid;
        pr_dirty = mem_q[flat(pr_set, pr_way)].dirty;
        pr_tag   = mem_q[flat(pr_set, pr_way)].tag;
    end

    // lowest matching way wins
    always_comb begin
        lk_hit   = 1'b0;
        lk_way   = '0;
        lk_dirty = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mem_q[flat(lk_set, WAY_W'(w))].valid && mem_q[flat(lk_set, WAY_W'(w))].tag == lk_tag) begin
                lk_hit   = 1'b1;
                lk_way   = WAY_W'(w);
                lk_dirty = mem_q[flat(lk_set, WAY_W'(w))].dirty;
            end
        end
    end

    // R9: no line may be dirty unless valid
    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        p_dirty_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            mem_q[e].dirty |-> mem_q[e].valid)
            else $error("dirty line %0d not valid", e);
    end
endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
    import dcm_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_all,
    input  logic             start_line,
    input  mop_e             start_op,
    input  logic [SET_W-1:0] line_set,
    input  logic             lk_hit,
    input  logic [WAY_W-1:0] lk_way,
    input  logic             lk_dirty,
    input  logic             rd_valid,
    input  logic             rd_dirty,
    input  logic             wb_ready,
    output logic             busy,
    output logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way,
    output logic             upd_en,
    output logic [SET_W-1:0] upd_set,
    output logic [WAY_W-1:0] upd_way,
    output logic             upd_clr_valid,
    output logic             upd_clr_dirty,
    output logic             wb_valid
);
    typedef struct packed {
        wst_e             st;
        mop_e             op;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic             line;
    } wk_t;

    wk_t wk_q, wk_d;
    logic cur_wb;
    logic last_ent;

    always_comb begin
        wk_d          = wk_q;
        upd_en        = 1'b0;
        upd_set       = wk_q.set;
        upd_way       = wk_q.way;
        upd_clr_valid = 1'b0;
        upd_clr_dirty = 1'b0;
        wb_valid      = 1'b0;
        cur_wb        = rd_valid && rd_dirty && (wk_q.op != MOP_INV_DROP);
        last_ent      = (wk_q.set == SET_W'(SETS - 1)) && (wk_q.way == WAY_W'(WAYS - 1));

        case (wk_q.st)
            ST_IDLE: begin
                if (start_all) begin
                    wk_d.st   = ST_WALK;
                    wk_d.op   = start_op;
                    wk_d.set  = '0;
                    wk_d.way  = '0;
                    wk_d.line = 1'b0;
                end else if (start_line && lk_hit) begin
                    if (lk_dirty && start_op != MOP_INV_DROP) begin
                        wk_d.st   = ST_WB;
                        wk_d.op   = start_op;
                        wk_d.set  = line_set;
                        wk_d.way  = lk_way;
                        wk_d.line = 1'b1;
                    end else if (start_op != MOP_FLUSH) begin
                        upd_en        = 1'b1;
                        upd_set       = line_set;
                        upd_way       = lk_way;
                        upd_clr_valid = 1'b1;
                        upd_clr_dirty = 1'b1;
                    end
                end
            end
            ST_WALK: begin
                if (cur_wb) begin
                    wk_d.st = ST_WB;
                end else begin
                    if (wk_q.op != MOP_FLUSH) begin
                        upd_en        = 1'b1;
                        upd_clr_valid = 1'b1;
                        upd_clr_dirty = 1'b1;
                    end
                    if (last_ent) begin
                        wk_d.st = ST_IDLE;
                    end else if (wk_q.way == WAY_W'(WAYS - 1)) begin
                        wk_d.way = '0;
                        wk_d.set = wk_q.set + 1'b1;
                    end else begin
                        wk_d.way = wk_q.way + 1'b1;
                    end
                end
            end
            ST_WB: begin
                wb_valid = 1'b1;
                if (wb_ready) begin
                    upd_en        = 1'b1;
                    upd_clr_dirty = 1'b1;
                    upd_clr_valid = (wk_q.op != MOP_FLUSH);
                    if (wk_q.line || last_ent) begin
                        wk_d.st = ST_IDLE;
                    end else begin
                        wk_d.st = ST_WALK;
                        if (wk_q.way == WAY_W'(WAYS - 1)) begin
                            wk_d.way = '0;
                            wk_d.set = wk_q.set + 1'b1;
                        end else begin
                            wk_d.way = wk_q.way + 1'b1;
                        end
                    end
                end
            end
            default: wk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '{st: ST_IDLE, op: MOP_INV_DROP, set: '0, way: '0, line: 1'b0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy   = (wk_q.st != ST_IDLE);
    assign rd_set = wk_q.set;
    assign rd_way = wk_q.way;

    // R7: a pending write-back request must not move until taken
    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(rd_set) && $stable(rd_way))
        else $error("write-back request changed while stalled");
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import dcm_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int OFF_W = 5,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ready,
    output logic [31:0]      bus_rdata,
    output logic             dc_disable,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic [SET_W-1:0] probe_set,
    input  logic [WAY_W-1:0] probe_way,
    output logic             probe_valid,
    output logic             probe_dirty,
    output logic [TAG_W-1:0] probe_tag,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [SET_W-1:0] wb_set,
    output logic [WAY_W-1:0] wb_way,
    output logic [TAG_W-1:0] wb_tag
);
    typedef struct packed {
        logic             dis;
        logic             mode;
        logic [TAG_W-1:0] ptag;
    } regs_t;

    regs_t rg_q, rg_d;

    logic             busy;
    logic             wr_acc;
    logic             start_all, start_line;
    mop_e             start_op;
    logic [SET_W-1:0] line_set;
    logic             lk_hit, lk_dirty;
    logic [WAY_W-1:0] lk_way;
    logic [SET_W-1:0] rd_set, upd_set;
    logic [WAY_W-1:0] rd_way, upd_way;
    logic             rd_valid, rd_dirty;
    logic             upd_en, upd_clr_valid, upd_clr_dirty;
    mop_e             inv_op;

    assign bus_ready = !busy || !bus_we;
    assign wr_acc    = bus_req && bus_we && bus_ready;
    assign line_set  = bus_wdata[OFF_W +: SET_W];
    assign inv_op    = rg_q.mode ? MOP_INV_WB : MOP_INV_DROP;

    always_comb begin
        rg_d       = rg_q;
        start_all  = 1'b0;
        start_line = 1'b0;
        start_op   = inv_op;
        if (wr_acc) begin
            case (bus_addr)
                RA_CTRL: begin
                    rg_d.dis  = bus_wdata[0];
                    rg_d.mode = bus_wdata[6];
                end
                RA_PTAG:     rg_d.ptag = bus_wdata[TAG_W-1:0];
                RA_ALL_INV:  start_all = bus_wdata[0];
                RA_ALL_FLS: begin
                    start_all = bus_wdata[0];
                    start_op  = MOP_FLUSH;
                end
                RA_LINE_INV: start_line = 1'b1;
                RA_LINE_FLS: begin
                    start_line = 1'b1;
                    start_op   = MOP_FLUSH;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL: begin
                bus_rdata[0] = rg_q.dis;
                bus_rdata[6] = rg_q.mode;
                bus_rdata[8] = busy;
            end
            RA_PTAG: bus_rdata[TAG_W-1:0] = rg_q.ptag;
            default: ;
        endcase
    end

    assign dc_disable = rg_q.dis;

    dcm_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
        .upd_clr_valid(upd_clr_valid), .upd_clr_dirty(upd_clr_dirty),
        .rd_set(rd_set), .rd_way(rd_way),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(wb_tag),
        .lk_set(line_set), .lk_tag(rg_q.ptag),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_dirty(lk_dirty),
        .pr_set(probe_set), .pr_way(probe_way),
        .pr_valid(probe_valid), .pr_dirty(probe_dirty), .pr_tag(probe_tag)
    );

    dcm_walker #(.SETS(SETS), .WAYS(WAYS)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .start_all(start_all), .start_line(start_line), .start_op(start_op),
        .line_set(line_set),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_dirty(lk_dirty),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .wb_ready(wb_ready), .busy(busy),
        .rd_set(rd_set), .rd_way(rd_way),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
        .upd_clr_valid(upd_clr_valid), .upd_clr_dirty(upd_clr_dirty),
        .wb_valid(wb_valid)
    );

    assign wb_set = rd_set;
    assign wb_way = rd_way;

    // R3: busy only rises after a command was accepted
    p_busy_from_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_all || start_line))
        else $error("busy rose without a command");

    // R11: a line command that misses never makes the block busy
    p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_line && !lk_hit |=> !busy)
        else $error("line miss raised busy");

    // R4: no register write is taken during an operation
    p_no_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rg_q.ptag) && $stable(rg_q.mode))
        else $error("register changed while busy");
endmodule

// File: tb/dcache_maint_ctrl_bench.sv
module dcache_maint_ctrl_bench;
    localparam int SETS  = 4;
    localparam int WAYS  = 2;
    localparam int TAG_W = 8;
    localparam int OFF_W = 4;
    localparam int NENT  = SETS * WAYS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        dc_disable;
    logic        fill_en = 1'b0, fill_dirty = 1'b0;
    logic [1:0]  fill_set = '0, probe_set = '0, wb_set;
    logic [0:0]  fill_way = '0, probe_way = '0, wb_way;
    logic [7:0]  fill_tag = '0, probe_tag, wb_tag;
    logic        probe_valid, probe_dirty, wb_valid;
    logic        wb_ready = 1'b1;
    logic        bp = 1'b0;

    int checks = 0, fails = 0, cyc = 0;
    int wb_cnt = 0;
    int wb_log [16];
    logic [7:0] wb_tlog [16];

    always #10 clk = ~clk;

    dcache_maint_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_dcache_maint_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .dc_disable(dc_disable),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .probe_set(probe_set), .probe_way(probe_way), .probe_valid(probe_valid),
        .probe_dirty(probe_dirty), .probe_tag(probe_tag),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set),
        .wb_way(wb_way), .wb_tag(wb_tag)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wb_valid && wb_ready) begin
            if (wb_cnt < 16) begin
                wb_log[wb_cnt]  = int'(wb_set) * WAYS + int'(wb_way);
                wb_tlog[wb_cnt] = wb_tag;
            end
            wb_cnt = wb_cnt + 1;
        end
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) wb_ready <= bp ? ~wb_ready : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic busy_now(output logic b);
        logic [31:0] d;
        rd(12'h048, d);
        b = d[8];
    endtask

    // returns at the falling edge after the accepting rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, output int stalls);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        stalls = 0;
        #1;
        while (!bus_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic fill(input int s, input int w, input logic [7:0] t, input logic dty);
        @(negedge clk);
        fill_en = 1'b1; fill_set = 2'(s); fill_way = 1'(w); fill_tag = t; fill_dirty = dty;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic probe(input int s, input int w);
        probe_set = 2'(s); probe_way = 1'(w);
        #1;
    endtask

    task automatic count_busy(output int n);
        logic b;
        n = 0;
        busy_now(b);
        while (b) begin
            n++;
            @(negedge clk);
            busy_now(b);
        end
    endtask

    // dirty pattern as a bit mask over flat entries
    task automatic fill_all(input logic [7:0] dmask);
        for (int e = 0; e < NENT; e++) fill(e / WAYS, e % WAYS, 8'(8'h20 + e), dmask[e]);
    endtask

    // {pre_dirty, mode, is_flush, tag_match, exp_valid, exp_dirty, exp_wb}
    localparam logic [6:0] VECS [8] = '{
        7'b0001000, 7'b1001000, 7'b1101001, 7'b0101000,
        7'b1011101, 7'b0011100, 7'b1100110, 7'b1010110
    };

    initial begin
        int st, n;
        logic [31:0] d;
        logic b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h048, d); chk("R1 ctrl reset", d, 32'h0);
        rd(12'h05C, d); chk("R1 ptag reset", d, 32'h0);
        chk("R1 disable output", 32'(dc_disable), 32'h0);
        probe(1, 1); chk("R1 line invalid", 32'(probe_valid), 32'h0);

        // R2 control fields
        wr(12'h048, 32'h41, st);
        rd(12'h048, d); chk("R2 ctrl readback", d, 32'h41);
        chk("R2 disable output", 32'(dc_disable), 32'h1);
        wr(12'h048, 32'h100, st);
        rd(12'h048, d); chk("R2 busy bit read-only", d, 32'h0);

        // line command table: R9 R10 R11
        for (int v = 0; v < 8; v++) begin
            logic [6:0] t;
            t = VECS[v];
            fill(2, 0, 8'h11, 1'b0);
            fill(2, 1, 8'h5A, t[6]);
            wr(12'h048, {25'b0, t[5], 6'b0}, st);
            wr(12'h05C, t[3] ? 32'h5A : 32'h33, st);
            wb_cnt = 0;
            wr(t[4] ? 12'h04C : 12'h04A, 32'h20, st);
            busy_now(b);
            chk($sformatf("R11 R9 R10 vec%0d busy after command", v), 32'(b), 32'(t[0]));
            count_busy(n);
            probe(2, 1);
            chk($sformatf("R9 R10 R11 vec%0d valid", v), 32'(probe_valid), 32'(t[2]));
            chk($sformatf("R9 R10 R11 vec%0d dirty", v), 32'(probe_dirty), 32'(t[1]));
            chk($sformatf("R9 R10 R11 vec%0d writebacks", v), 32'(wb_cnt), 32'(t[0]));
            if (t[0]) chk($sformatf("R10 vec%0d wb tag", v), 32'(wb_tlog[0]), 32'h5A);
            probe(2, 0);
            chk($sformatf("R11 vec%0d other way untouched", v), 32'(probe_valid), 32'h1);
        end

        // R5 R12 entire invalidate, discard mode
        fill_all(8'b1001_0010);
        wr(12'h048, 32'h0, st);
        wb_cnt = 0;
        wr(12'h047, 32'h1, st);
        count_busy(n);
        chk("R12 discard walk busy cycles", n, NENT);
        chk("R5 no writebacks", wb_cnt, 0);
        for (int e = 0; e < NENT; e++) begin
            probe(e / WAYS, e % WAYS);
            chk($sformatf("R5 entry %0d cleared", e), {probe_valid, probe_dirty}, 32'h0);
        end

        // R6 R12 entire invalidate with write-back
        fill_all(8'b1001_0010);
        wr(12'h048, 32'h40, st);
        wb_cnt = 0;
        wr(12'h047, 32'h1, st);
        count_busy(n);
        chk("R12 writeback walk busy cycles", n, NENT + 3);
        chk("R6 writeback count", wb_cnt, 3);
        for (int e = 0; e < NENT; e++) begin
            probe(e / WAYS, e % WAYS);
            chk($sformatf("R6 entry %0d cleared", e), {probe_valid, probe_dirty}, 32'h0);
        end

        // R7 R3 R4 entire flush with back-pressure
        fill_all(8'b1001_0010);
        wr(12'h048, 32'h0, st);
        wb_cnt = 0;
        bp = 1'b1;
        wr(12'h04B, 32'h1, st);
        busy_now(b);
        chk("R3 busy during flush", 32'(b), 32'h1);
        wr(12'h05C, 32'h77, st);
        chk("R4 write stalled while busy", 32'(st > 0), 32'h1);
        busy_now(b);
        chk("R4 write taken only when idle", 32'(b), 32'h0);
        rd(12'h05C, d); chk("R4 stalled write applied", d, 32'h77);
        bp = 1'b0;
        chk("R7 flush writeback count", wb_cnt, 3);
        chk("R7 order first", wb_log[0], 1);
        chk("R7 order second", wb_log[1], 4);
        chk("R7 order third", wb_log[2], 7);
        chk("R7 tag of third", 32'(wb_tlog[2]), 32'h27);
        for (int e = 0; e < NENT; e++) begin
            probe(e / WAYS, e % WAYS);
            chk($sformatf("R7 entry %0d valid clean", e), {probe_valid, probe_dirty}, 32'h2);
        end
        rd(12'h048, d); chk("R3 busy clear after flush", d, 32'h0);

        // R8 commands without bit 0
        fill_all(8'b1111_1111);
        wb_cnt = 0;
        wr(12'h047, 32'h0, st);
        busy_now(b); chk("R8 invalidate ignored busy", 32'(b), 32'h0);
        wr(12'h04B, 32'h2, st);
        busy_now(b); chk("R8 flush ignored busy", 32'(b), 32'h0);
        chk("R8 no writebacks", wb_cnt, 0);
        probe(3, 1);
        chk("R8 line unchanged", {probe_valid, probe_dirty}, 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule